// File: doc/BRIEF.md
# LPC I/O Mailbox Target

This block is the peripheral side of a Low Pin Count bus. It watches the four-bit multiplexed address/data lines, which are qualified by an active-low frame strobe. It claims only I/O read and I/O write cycles. Every other cycle type passes unanswered and leaves the bus alone. A claimed cycle is completed by the block: it drives a ready sync nibble, any read data, and the first clock of the turnaround back to the host.

Behind the bus sit three mailbox channels in the style of a keyboard controller. Each channel has three bytes:
- an inbound byte that the host writes;
- an outbound byte that the host reads;
- a status byte that carries the full flags and a flag recording whether the last write used the command address.

Two channels answer at fixed port pairs. The third channel answers at a base address that the embedded side programs, and it also carries sixteen general bytes that both sides can read and write. A plain local strobe port gives the embedded controller access to all of this state.

Top module: `lpc_mbox_target`

## Requirements
- R1: Only cycle-type nibble 4'b0000 (I/O read) and 4'b0010 (I/O write) are claimed. For any other type, `lad_oe` stays low for the whole cycle and no mailbox state changes.
- R2: A cycle is framed as follows. While `lframe_n` is low, a start nibble of 4'b0000 appears. On the first clock with `lframe_n` high, the cycle-type nibble appears. Then come four address nibbles, most significant first. For a write, two data nibbles follow, low nibble first.
- R3: Channel 1 decodes 0x0060 as data and 0x0064 as command/status. Channel 2 decodes 0x0062 and 0x0066. An address that matches nothing is never answered.
- R4: The channel 3 base is held in local registers 0x0C (low byte) and 0x0D (high byte), and resets to 0x0CA0. Channel 3 data sits at base, command/status at base+4, and general byte k at base+0x10+k.
- R5: On a claimed cycle, the host drives two turnaround clocks after its last nibble. The target then drives 4'b0000 for one clock. On a read, the target next drives the data byte low nibble first.
- R6: After its sync (write) or its data (read), the target drives 4'b1111 for one clock and then releases LAD. `lad_oe` is low in every other phase.
- R7: A host write to a channel's data or command address stores the byte in that channel's inbound register. It sets IBF (status bit 1). It sets CMD (status bit 3) to 1 for the command address and to 0 for the data address.
- R8: `lframe_n` low in the middle of a cycle abandons that cycle with no state change. If LAD reads 4'b0000 at that moment, it is taken as a new start.
- R9: While `lreset_n` is low, the target returns to idle with `lad_oe` low, and all flags and data bytes clear.
- R10: A host read of a data address returns the outbound byte and clears OBF (status bit 0). A host read of a command address returns the status byte `{4'b0, CMD, 1'b0, IBF, OBF}` and changes nothing.
- R11: Local address 4*c (c = 0..2) reads the inbound byte. A write there loads the outbound byte and sets OBF. A one-clock `loc_rd` strobe there clears IBF. Local address 4*c+1 reads the status byte.
- R12: Local addresses 0x10+k read and write general byte k. The host reaches the same byte at base+0x10+k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lclk | input | 1 | Bus clock |
| lreset_n | input | 1 | Active-low bus reset |
| lframe_n | input | 1 | Active-low cycle frame strobe |
| lad_i | input | 4 | Nibble sampled from the LAD lines |
| lad_o | output | 4 | Nibble the target drives onto LAD |
| lad_oe | output | 1 | High while the target drives LAD |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read-side-effect strobe |
| loc_addr | input | 6 | Local register address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data (combinational from state) |

## Verification
The bench builds the block with its default parameters: a 16-bit I/O address, sixteen general bytes, and a channel 3 base that resets to 0x0CA0. With these defaults the bench drives every channel through its fixed or programmed address. It then moves the third base at run time, so the old window goes dark and the new one answers. It also uses the full set of general bytes to carry traffic in both directions between host and local sides.

// File: rtl/lpc_mbox_pkg.sv
package lpc_mbox_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR,
        ST_WDATA,
        ST_TAR1,
        ST_TAR2,
        ST_SYNC,
        ST_RDATA,
        ST_TB1,
        ST_TB2
    } lpc_state_e;

    typedef enum logic [1:0] {
        K_NONE,
        K_DATA,
        K_CMD,
        K_EXTRA
    } acc_kind_e;

    localparam logic [3:0] NIB_START = 4'b0000;
    localparam logic [3:0] CT_IORD   = 4'b0000;
    localparam logic [3:0] CT_IOWR   = 4'b0010;
    localparam logic [3:0] NIB_SYNC  = 4'b0000;
    localparam logic [3:0] NIB_TAR   = 4'b1111;

    localparam int STS_OBF = 0;
    localparam int STS_IBF = 1;
    localparam int STS_CMD = 3;

endpackage

// File: rtl/lpc_frame_fsm.sv
module lpc_frame_fsm
    import lpc_mbox_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lframe_n,
    input  logic [3:0]        lad_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe,
    output logic [ADDR_W-1:0] addr_o,
    input  logic              hit_i,
    output logic              wr_o,
    output logic              rd_o,
    output logic [7:0]        wdata_o,
    input  logic [7:0]        rdata_i
);
    localparam int ANIB = ADDR_W / 4;
    localparam int CW   = (ANIB > 2) ? $clog2(ANIB) : 1;

    typedef struct packed {
        lpc_state_e        state;
        logic [CW-1:0]     cnt;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdat;
        logic [7:0]        rdat;
    } fsm_t;

    fsm_t q, d;

    always_comb begin
        d    = q;
        wr_o = 1'b0;
        rd_o = 1'b0;
        if (!lframe_n) begin
            d.state = (lad_i == NIB_START) ? ST_START : ST_IDLE;
            d.cnt   = '0;
        end else begin
            unique case (q.state)
                ST_START: begin
                    d.cnt = '0;
                    if (lad_i == CT_IORD) begin
                        d.state = ST_ADDR;
                        d.is_wr = 1'b0;
                    end else if (lad_i == CT_IOWR) begin
                        d.state = ST_ADDR;
                        d.is_wr = 1'b1;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    d.addr = {q.addr[ADDR_W-5:0], lad_i};
                    if (q.cnt == CW'(ANIB - 1)) begin
                        d.cnt   = '0;
                        d.state = q.is_wr ? ST_WDATA : ST_TAR1;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_WDATA: begin
                    if (q.cnt == '0) begin
                        d.wdat[3:0] = lad_i;
                        d.cnt       = CW'(1);
                    end else begin
                        d.wdat[7:4] = lad_i;
                        d.cnt       = '0;
                        d.state     = ST_TAR1;
                    end
                end
                ST_TAR1: d.state = ST_TAR2;
                ST_TAR2: begin
                    if (hit_i) begin
                        d.state = ST_SYNC;
                        wr_o    = q.is_wr;
                        rd_o    = !q.is_wr;
                        d.rdat  = rdata_i;
                    end else begin
                        d.state = ST_IDLE;
                    end
                end
                ST_SYNC: begin
                    d.cnt   = '0;
                    d.state = q.is_wr ? ST_TB1 : ST_RDATA;
                end
                ST_RDATA: begin
                    if (q.cnt == '0) begin
                        d.cnt = CW'(1);
                    end else begin
                        d.cnt   = '0;
                        d.state = ST_TB1;
                    end
                end
                ST_TB1:  d.state = ST_TB2;
                ST_TB2:  d.state = ST_IDLE;
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        lad_o  = NIB_TAR;
        lad_oe = 1'b0;
        unique case (q.state)
            ST_SYNC: begin
                lad_o  = NIB_SYNC;
                lad_oe = 1'b1;
            end
            ST_RDATA: begin
                lad_o  = (q.cnt == '0) ? q.rdat[3:0] : q.rdat[7:4];
                lad_oe = 1'b1;
            end
            ST_TB1: begin
                lad_o  = NIB_TAR;
                lad_oe = 1'b1;
            end
            default: ;
        endcase
    end

    assign addr_o  = q.addr;
    assign wdata_o = q.wdat;

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/lpc_addr_decode.sv
module lpc_addr_decode
    import lpc_mbox_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              NUM_CH    = 3,
    parameter int              NUM_EXTRA = 16,
    parameter logic [ADDR_W-1:0] CH1_DATA = 16'h0060,
    parameter logic [ADDR_W-1:0] CH1_CMD  = 16'h0064,
    parameter logic [ADDR_W-1:0] CH2_DATA = 16'h0062,
    parameter logic [ADDR_W-1:0] CH2_CMD  = 16'h0066,
    parameter int              CMD_OFS   = 4,
    parameter int              X_OFS     = 16,
    localparam int             CHW       = $clog2(NUM_CH),
    localparam int             XW        = $clog2(NUM_EXTRA)
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              hit_o,
    output acc_kind_e         kind_o,
    output logic [CHW-1:0]    ch_o,
    output logic [XW-1:0]     xidx_o
);
    logic [ADDR_W-1:0] off;
    logic [ADDR_W-1:0] xoff;

    always_comb begin
        off    = addr_i - base_i;
        xoff   = off - ADDR_W'(X_OFS);
        kind_o = K_NONE;
        ch_o   = '0;
        xidx_o = '0;
        if (addr_i == CH1_DATA) begin
            kind_o = K_DATA;
        end else if (addr_i == CH1_CMD) begin
            kind_o = K_CMD;
        end else if (addr_i == CH2_DATA) begin
            kind_o = K_DATA;
            ch_o   = CHW'(1);
        end else if (addr_i == CH2_CMD) begin
            kind_o = K_CMD;
            ch_o   = CHW'(1);
        end else if (off == '0) begin
            kind_o = K_DATA;
            ch_o   = CHW'(2);
        end else if (off == ADDR_W'(CMD_OFS)) begin
            kind_o = K_CMD;
            ch_o   = CHW'(2);
        end else if (xoff < ADDR_W'(NUM_EXTRA)) begin
            kind_o = K_EXTRA;
            ch_o   = CHW'(2);
            xidx_o = xoff[XW-1:0];
        end
        hit_o = (kind_o != K_NONE);
    end
endmodule

// File: rtl/lpc_mbox_regs.sv
module lpc_mbox_regs
    import lpc_mbox_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter int                NUM_CH    = 3,
    parameter int                NUM_EXTRA = 16,
    parameter int                LOC_AW    = 6,
    parameter logic [ADDR_W-1:0] BASE_RST  = 16'h0CA0,
    parameter int                LOC_BLO   = 12,
    parameter int                LOC_BHI   = 13,
    parameter int                LOC_X     = 16,
    localparam int               CHW       = $clog2(NUM_CH),
    localparam int               XW        = $clog2(NUM_EXTRA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  acc_kind_e         host_kind,
    input  logic [CHW-1:0]    host_ch,
    input  logic [XW-1:0]     host_xidx,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              loc_wr,
    input  logic              loc_rd,
    input  logic [LOC_AW-1:0] loc_addr,
    input  logic [7:0]        loc_wdata,
    output logic [7:0]        loc_rdata,
    output logic [ADDR_W-1:0] base_o,
    output logic [NUM_CH-1:0] ibf_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][7:0]    idr;
        logic [NUM_CH-1:0][7:0]    odr;
        logic [NUM_CH-1:0]         ibf;
        logic [NUM_CH-1:0]         obf;
        logic [NUM_CH-1:0]         cmd;
        logic [ADDR_W-1:0]         base;
        logic [NUM_EXTRA-1:0][7:0] xb;
    } regs_t;

    regs_t q, d;

    function automatic logic [7:0] sts_byte(input logic c, input logic i, input logic o);
        logic [7:0] s;
        s          = 8'h00;
        s[STS_CMD] = c;
        s[STS_IBF] = i;
        s[STS_OBF] = o;
        return s;
    endfunction

    always_comb begin
        d = q;
        // local read strobe clears IBF first so that a host write in the same clock wins
        for (int c = 0; c < NUM_CH; c++) begin
            if (loc_rd && loc_addr == LOC_AW'(c * 4)) d.ibf[c] = 1'b0;
        end
        for (int k = 0; k < NUM_EXTRA; k++) begin
            if (loc_wr && loc_addr == LOC_AW'(LOC_X + k)) d.xb[k] = loc_wdata;
        end
        if (loc_wr && loc_addr == LOC_AW'(LOC_BLO)) d.base[7:0]        = loc_wdata;
        if (loc_wr && loc_addr == LOC_AW'(LOC_BHI)) d.base[ADDR_W-1:8] = loc_wdata;
        // host side effects
        for (int c = 0; c < NUM_CH; c++) begin
            if (host_ch == CHW'(c)) begin
                if (host_wr && (host_kind == K_DATA || host_kind == K_CMD)) begin
                    d.idr[c] = host_wdata;
                    d.ibf[c] = 1'b1;
                    d.cmd[c] = (host_kind == K_CMD);
                end
                if (host_rd && host_kind == K_DATA) d.obf[c] = 1'b0;
            end
        end
        if (host_wr && host_kind == K_EXTRA) d.xb[host_xidx] = host_wdata;
        // local outbound load last so fresh data keeps OBF set
        for (int c = 0; c < NUM_CH; c++) begin
            if (loc_wr && loc_addr == LOC_AW'(c * 4)) begin
                d.odr[c] = loc_wdata;
                d.obf[c] = 1'b1;
            end
        end
    end

    always_comb begin
        host_rdata = 8'h00;
        for (int c = 0; c < NUM_CH; c++) begin
            if (host_ch == CHW'(c)) begin
                if (host_kind == K_DATA) host_rdata = q.odr[c];
                if (host_kind == K_CMD)  host_rdata = sts_byte(q.cmd[c], q.ibf[c], q.obf[c]);
            end
        end
        if (host_kind == K_EXTRA) host_rdata = q.xb[host_xidx];
    end

    always_comb begin
        loc_rdata = 8'h00;
        for (int c = 0; c < NUM_CH; c++) begin
            if (loc_addr == LOC_AW'(c * 4))     loc_rdata = q.idr[c];
            if (loc_addr == LOC_AW'(c * 4 + 1)) loc_rdata = sts_byte(q.cmd[c], q.ibf[c], q.obf[c]);
        end
        if (loc_addr == LOC_AW'(LOC_BLO)) loc_rdata = q.base[7:0];
        if (loc_addr == LOC_AW'(LOC_BHI)) loc_rdata = q.base[ADDR_W-1:8];
        for (int k = 0; k < NUM_EXTRA; k++) begin
            if (loc_addr == LOC_AW'(LOC_X + k)) loc_rdata = q.xb[k];
        end
    end

    assign base_o = q.base;
    assign ibf_o  = q.ibf;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.base <= BASE_RST;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/lpc_mbox_target.sv
module lpc_mbox_target
    import lpc_mbox_pkg::*;
#(
    parameter int                ADDR_W       = 16,
    parameter int                NUM_EXTRA    = 16,
    parameter int                LOC_AW       = 6,
    parameter logic [ADDR_W-1:0] CH3_BASE_RST = 16'h0CA0
) (
    input  logic              lclk,
    input  logic              lreset_n,
    input  logic              lframe_n,
    input  logic [3:0]        lad_i,
    output logic [3:0]        lad_o,
    output logic              lad_oe,
    input  logic              loc_wr,
    input  logic              loc_rd,
    input  logic [LOC_AW-1:0] loc_addr,
    input  logic [7:0]        loc_wdata,
    output logic [7:0]        loc_rdata
);
    localparam int NUM_CH = 3;
    localparam int CHW    = $clog2(NUM_CH);
    localparam int XW     = $clog2(NUM_EXTRA);

    logic [ADDR_W-1:0] cyc_addr;
    logic [ADDR_W-1:0] ch3_base;
    logic              dec_hit;
    acc_kind_e         dec_kind;
    logic [CHW-1:0]    dec_ch;
    logic [XW-1:0]     dec_xidx;
    logic              host_wr;
    logic              host_rd;
    logic [7:0]        host_wdata;
    logic [7:0]        host_rdata;
    logic [NUM_CH-1:0] ibf_vec;
    logic [NUM_CH-1:0] wr_ch_vec;

    lpc_frame_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk     (lclk),
        .rst_n   (lreset_n),
        .lframe_n(lframe_n),
        .lad_i   (lad_i),
        .lad_o   (lad_o),
        .lad_oe  (lad_oe),
        .addr_o  (cyc_addr),
        .hit_i   (dec_hit),
        .wr_o    (host_wr),
        .rd_o    (host_rd),
        .wdata_o (host_wdata),
        .rdata_i (host_rdata)
    );

    lpc_addr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CH   (NUM_CH),
        .NUM_EXTRA(NUM_EXTRA)
    ) u_dec (
        .addr_i(cyc_addr),
        .base_i(ch3_base),
        .hit_o (dec_hit),
        .kind_o(dec_kind),
        .ch_o  (dec_ch),
        .xidx_o(dec_xidx)
    );

    lpc_mbox_regs #(
        .ADDR_W   (ADDR_W),
        .NUM_CH   (NUM_CH),
        .NUM_EXTRA(NUM_EXTRA),
        .LOC_AW   (LOC_AW),
        .BASE_RST (CH3_BASE_RST)
    ) u_regs (
        .clk       (lclk),
        .rst_n     (lreset_n),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_kind (dec_kind),
        .host_ch   (dec_ch),
        .host_xidx (dec_xidx),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .loc_wr    (loc_wr),
        .loc_rd    (loc_rd),
        .loc_addr  (loc_addr),
        .loc_wdata (loc_wdata),
        .loc_rdata (loc_rdata),
        .base_o    (ch3_base),
        .ibf_o     (ibf_vec)
    );

    always_comb begin
        wr_ch_vec = '0;
        if (host_wr && (dec_kind == K_DATA || dec_kind == K_CMD)) wr_ch_vec[dec_ch] = 1'b1;
    end
endmodule

// File: rtl/lpc_mbox_checker.sv
module lpc_mbox_checker #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lframe_n,
    input logic              lad_oe,
    input logic [3:0]        lad_o,
    input logic              host_wr,
    input logic              host_rd,
    input logic [NUM_CH-1:0] wr_vec,
    input logic [NUM_CH-1:0] ibf
);
    assert_reset_release_R9: assert property (@(posedge clk)
        !rst_n |=> !lad_oe);

    assert_sync_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> lad_o == 4'b0000);

    assert_tar_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(lad_oe) && lframe_n && $past(lframe_n)) |-> $past(lad_o) == 4'b1111);

    assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !lframe_n |=> !lad_oe);

    assert_one_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_vec));

    assert_ibf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|wr_vec) |=> ((ibf & $past(wr_vec)) == $past(wr_vec)));

    assert_dir_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && host_rd));
endmodule

bind lpc_mbox_target lpc_mbox_checker #(.NUM_CH(3)) u_chk (
    .clk     (lclk),
    .rst_n   (lreset_n),
    .lframe_n(lframe_n),
    .lad_oe  (lad_oe),
    .lad_o   (lad_o),
    .host_wr (host_wr),
    .host_rd (host_rd),
    .wr_vec  (wr_ch_vec),
    .ibf     (ibf_vec)
);

// File: tb/tb_lpc_mbox_target.sv
module tb_lpc_mbox_target;
    localparam int CLK_PERIOD = 30;

    logic       lclk = 1'b0;
    logic       lreset_n = 1'b0;
    logic       lframe_n = 1'b1;
    logic [3:0] lad_i = 4'hF;
    logic [3:0] lad_o;
    logic       lad_oe;
    logic       loc_wr = 1'b0;
    logic       loc_rd = 1'b0;
    logic [5:0] loc_addr = '0;
    logic [7:0] loc_wdata = '0;
    logic [7:0] loc_rdata;

    int errors = 0;
    int checks = 0;

    // reference model
    logic [7:0]  m_idr [3];
    logic [7:0]  m_odr [3];
    bit          m_ibf [3];
    bit          m_obf [3];
    bit          m_cmd [3];
    logic [7:0]  m_xb  [16];
    logic [15:0] m_base;

    lpc_mbox_target dut (
        .lclk(lclk), .lreset_n(lreset_n), .lframe_n(lframe_n), .lad_i(lad_i),
        .lad_o(lad_o), .lad_oe(lad_oe), .loc_wr(loc_wr), .loc_rd(loc_rd),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
    );

    always #(CLK_PERIOD / 2) lclk = ~lclk;

    function automatic logic [7:0] m_sts(input int c);
        return {4'b0, m_cmd[c], 1'b0, m_ibf[c], m_obf[c]};
    endfunction

    // 0 none, 1 data, 2 command, 3 general byte; idx gets channel or byte index
    function automatic int m_dec(input logic [15:0] a, output int idx);
        logic [15:0] off;
        off = a - m_base;
        idx = 0;
        if (a == 16'h0060) return 1;
        if (a == 16'h0064) return 2;
        if (a == 16'h0062) begin idx = 1; return 1; end
        if (a == 16'h0066) begin idx = 1; return 2; end
        if (off == 0) begin idx = 2; return 1; end
        if (off == 4) begin idx = 2; return 2; end
        if (off >= 16 && off < 32) begin idx = int'(off) - 16; return 3; end
        return 0;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // compare the bus outputs of the previous clock, then drive the next nibble
    task automatic nib(input logic fr, input logic [3:0] v, input logic eoe,
                       input logic [3:0] el, input string req);
        @(negedge lclk);
        checks++;
        if (lad_oe !== eoe || (eoe && lad_o !== el)) begin
            errors++;
            $display("FAIL %s: actual oe=%b lad=%h expected oe=%b lad=%h",
                     req, lad_oe, lad_o, eoe, el);
        end
        lframe_n = fr;
        lad_i    = v;
    endtask

    task automatic host_io(input logic [3:0] ct, input bit send_data, input logic [15:0] a,
                           input logic [7:0] wd, input string req);
        int idx;
        int k;
        bit claimed;
        logic [7:0] r;
        k = m_dec(a, idx);
        claimed = (ct == 4'b0000 || ct == 4'b0010) && k != 0;
        r = 8'h00;
        if (k == 1) r = m_odr[idx];
        if (k == 2) r = m_sts(idx);
        if (k == 3) r = m_xb[idx];
        nib(1'b0, 4'b0000, 1'b0, 4'h0, req);
        nib(1'b1, ct, 1'b0, 4'h0, req);
        for (int i = 3; i >= 0; i--) nib(1'b1, a[i*4 +: 4], 1'b0, 4'h0, req);
        if (send_data) begin
            nib(1'b1, wd[3:0], 1'b0, 4'h0, req);
            nib(1'b1, wd[7:4], 1'b0, 4'h0, req);
        end
        nib(1'b1, 4'hF, 1'b0, 4'h0, req);
        nib(1'b1, 4'hF, 1'b0, 4'h0, req);
        if (claimed) begin
            nib(1'b1, 4'hF, 1'b1, 4'h0, req);
            if (ct == 4'b0000) begin
                nib(1'b1, 4'hF, 1'b1, r[3:0], req);
                nib(1'b1, 4'hF, 1'b1, r[7:4], req);
            end
            nib(1'b1, 4'hF, 1'b1, 4'hF, req);
            nib(1'b1, 4'hF, 1'b0, 4'h0, req);
            nib(1'b1, 4'hF, 1'b0, 4'h0, req);
            if (ct == 4'b0010) begin
                if (k == 1 || k == 2) begin
                    m_idr[idx] = wd;
                    m_ibf[idx] = 1'b1;
                    m_cmd[idx] = (k == 2);
                end
                if (k == 3) m_xb[idx] = wd;
            end else if (k == 1) begin
                m_obf[idx] = 1'b0;
            end
        end else begin
            for (int i = 0; i < 4; i++) nib(1'b1, 4'hF, 1'b0, 4'h0, req);
        end
    endtask

    task automatic loc_write(input logic [5:0] a, input logic [7:0] v);
        @(negedge lclk);
        loc_addr  = a;
        loc_wdata = v;
        loc_wr    = 1'b1;
        @(negedge lclk);
        loc_wr = 1'b0;
        for (int c = 0; c < 3; c++) begin
            if (a == 6'(c * 4)) begin
                m_odr[c] = v;
                m_obf[c] = 1'b1;
            end
        end
        if (a == 6'h0C) m_base[7:0]  = v;
        if (a == 6'h0D) m_base[15:8] = v;
        if (a >= 6'h10 && a <= 6'h1F) m_xb[a - 6'h10] = v;
    endtask

    task automatic loc_check(input logic [5:0] a, input logic [7:0] exp, input bit strobe,
                             input string req);
        @(negedge lclk);
        loc_addr = a;
        #1;
        check8(req, loc_rdata, exp);
        if (strobe) begin
            loc_rd = 1'b1;
            @(negedge lclk);
            loc_rd = 1'b0;
            for (int c = 0; c < 3; c++) if (a == 6'(c * 4)) m_ibf[c] = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge lclk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int c = 0; c < 3; c++) begin
            m_idr[c] = 0; m_odr[c] = 0; m_ibf[c] = 0; m_obf[c] = 0; m_cmd[c] = 0;
        end
        for (int k = 0; k < 16; k++) m_xb[k] = 0;
        m_base = 16'h0CA0;

        repeat (3) @(negedge lclk);
        checks++;
        if (lad_oe !== 1'b0) begin
            errors++;
            $display("FAIL R9: actual oe=%b expected oe=0", lad_oe);
        end
        lreset_n = 1'b1;

        // R9 / R4: reset values seen locally
        for (int c = 0; c < 3; c++) loc_check(6'(c * 4 + 1), 8'h00, 1'b0, "R9 status");
        loc_check(6'h0C, 8'hA0, 1'b0, "R4 base lo");
        loc_check(6'h0D, 8'h0C, 1'b0, "R4 base hi");

        // R2 R7: data write to channel 1
        host_io(4'b0010, 1'b1, 16'h0060, 8'h5A, "R7 wr data ch1");
        loc_check(6'h01, m_sts(0), 1'b0, "R7 status after data");
        loc_check(6'h00, 8'h5A, 1'b1, "R11 read idr");
        loc_check(6'h01, m_sts(0), 1'b0, "R11 ibf cleared");

        // R7: command write sets CMD
        host_io(4'b0010, 1'b1, 16'h0064, 8'hD1, "R7 wr cmd ch1");
        loc_check(6'h01, 8'h0A, 1'b0, "R7 cmd flag");
        loc_check(6'h00, 8'hD1, 1'b1, "R11 read cmd byte");

        // R3: channel 2 fixed pair
        host_io(4'b0010, 1'b1, 16'h0066, 8'h33, "R3 wr ch2 cmd");
        loc_check(6'h05, m_sts(1), 1'b0, "R3 ch2 status");
        loc_check(6'h04, 8'h33, 1'b0, "R3 ch2 idr");
        loc_check(6'h01, m_sts(0), 1'b0, "R3 ch1 untouched");

        // R10 R5 R6: outbound path
        loc_write(6'h00, 8'h77);
        loc_check(6'h01, m_sts(0), 1'b0, "R11 obf set");
        host_io(4'b0000, 1'b0, 16'h0064, 8'h00, "R10 status read");
        host_io(4'b0000, 1'b0, 16'h0064, 8'h00, "R10 status read no effect");
        host_io(4'b0000, 1'b0, 16'h0060, 8'h00, "R5 R6 data read");
        host_io(4'b0000, 1'b0, 16'h0064, 8'h00, "R10 obf cleared");
        loc_write(6'h04, 8'hC3);
        host_io(4'b0000, 1'b0, 16'h0062, 8'h00, "R10 ch2 data read");

        // R3: unmatched address
        host_io(4'b0000, 1'b0, 16'h0070, 8'h00, "R3 miss read");
        host_io(4'b0010, 1'b1, 16'h0061, 8'hEE, "R3 miss write");

        // R1: non-I/O types ignored
        host_io(4'b0100, 1'b0, 16'h0060, 8'h00, "R1 mem read");
        host_io(4'b0110, 1'b1, 16'h0060, 8'h99, "R1 mem write");
        loc_check(6'h01, m_sts(0), 1'b0, "R1 ch1 status unchanged");
        loc_check(6'h00, m_idr[0], 1'b0, "R1 ch1 idr unchanged");

        // R4: channel 3 at default base, then moved
        host_io(4'b0010, 1'b1, 16'h0CA0, 8'h11, "R4 ch3 default base");
        loc_check(6'h09, m_sts(2), 1'b0, "R4 ch3 status");
        loc_check(6'h08, 8'h11, 1'b1, "R4 ch3 idr");
        loc_write(6'h0C, 8'h00);
        loc_write(6'h0D, 8'h03);
        host_io(4'b0010, 1'b1, 16'h0CA4, 8'h22, "R4 old window dark");
        host_io(4'b0010, 1'b1, 16'h0304, 8'h44, "R4 new cmd address");
        loc_check(6'h09, 8'h0A, 1'b0, "R4 ch3 cmd flag");
        loc_write(6'h08, 8'h5C);
        host_io(4'b0000, 1'b0, 16'h0300, 8'h00, "R4 ch3 data read");

        // R12: general bytes both ways
        host_io(4'b0010, 1'b1, 16'h0313, 8'hBE, "R12 host wr byte 3");
        loc_check(6'h13, 8'hBE, 1'b0, "R12 local rd byte 3");
        loc_write(6'h1F, 8'h42);
        host_io(4'b0000, 1'b0, 16'h031F, 8'h00, "R12 host rd byte 15");
        loc_write(6'h10, 8'h07);
        host_io(4'b0000, 1'b0, 16'h0310, 8'h00, "R12 host rd byte 0");

        // R8: abort a write mid-address, restart at once
        nib(1'b0, 4'b0000, 1'b0, 4'h0, "R8 start");
        nib(1'b1, 4'b0010, 1'b0, 4'h0, "R8 type");
        nib(1'b1, 4'h0, 1'b0, 4'h0, "R8 addr");
        nib(1'b1, 4'h0, 1'b0, 4'h0, "R8 addr");
        host_io(4'b0000, 1'b0, 16'h0066, 8'h00, "R8 restart read");
        loc_check(6'h01, m_sts(0), 1'b0, "R8 no write after abort");

        // R8: abort during target sync, then a clean cycle
        nib(1'b0, 4'b0000, 1'b0, 4'h0, "R8 start2");
        nib(1'b1, 4'b0000, 1'b0, 4'h0, "R8 type2");
        for (int i = 3; i >= 0; i--) nib(1'b1, 4'(16'h0064 >> (i * 4)), 1'b0, 4'h0, "R8 addr2");
        nib(1'b1, 4'hF, 1'b0, 4'h0, "R8 tar");
        nib(1'b1, 4'hF, 1'b0, 4'h0, "R8 tar");
        nib(1'b0, 4'hF, 1'b1, 4'h0, "R8 sync before abort");
        nib(1'b1, 4'hF, 1'b0, 4'h0, "R8 released");
        host_io(4'b0000, 1'b0, 16'h0064, 8'h00, "R8 clean after abort");

        repeat (2) @(negedge lclk);
        finish_run();
    end
endmodule